// File: doc/BRIEF.md
# Toggle-Started Dual Interval Timer

This block times two intervals, a long one and a short one, for a traffic-light sequencer. The sequencer restarts the timer by flipping the level of a single start line. A rising change and a falling change have the same effect, so the sequencer only has to invert one bit on each phase change. Both intervals start again from zero on every such change.

Time is measured in ticks of a shared clock-enable strobe, for example a one-second pulse made elsewhere. One counter serves each interval. A counter advances only in a cycle where the strobe is high. When its count reaches the configured length, it raises its done flag. The flag then stays high and the counter stops until the next restart. A synchronous reset clears both counters, both flags and the start-line history.

Top module: `toggle_interval_timer`

## Requirements
- R1: While `rst` is high, both `long_done` and `short_done` are driven low at each clock edge, and the start-line history is cleared to low.
- R2: A level change on `start_lvl` restarts both intervals. The change is sampled at one clock edge. At the following edge both flags go low and both counts go to zero. Both directions of change behave the same.
- R3: `long_done` goes high at the clock edge that registers the LONG_TICKS-th counted tick after a restart.
- R4: `short_done` goes high at the clock edge that registers the SHORT_TICKS-th counted tick after a restart.
- R5: A cycle with `tick` low leaves both counts and both flags unchanged.
- R6: Once set, a done flag stays high, and further ticks have no effect on it, until the next restart.
- R7: When a restart and a high `tick` fall in the same cycle, the restart takes effect and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe; each high cycle counts as one tick |
| start_lvl | input | 1 | Start line; every level change restarts both intervals |
| long_done | output | 1 | Registered flag; high once the long interval has elapsed |
| short_done | output | 1 | Registered flag; high once the short interval has elapsed |

## Verification
The bench sets LONG_TICKS to 12 and SHORT_TICKS to 3. With these values both flags rise within a few dozen cycles, so a pseudo-random phase of a few thousand cycles covers many restarts of both directions, restarts before and after each flag has set, and many strobe gaps. The value 12 still needs a 4-bit count. Directed steps place a restart in the same cycle as a tick, and they hold the strobe low while flags are set, to check R5, R6 and R7 at the output flags.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int DEF_LONG_TICKS  = 30;
  localparam int DEF_SHORT_TICKS = 4;
  localparam int NUM_SLOTS       = 2;
  localparam int SLOT_LONG       = 0;
  localparam int SLOT_SHORT      = 1;
endpackage

// File: rtl/itimer_toggle_det.sv
module itimer_toggle_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic restart
);
  logic smp_now;
  logic smp_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_now  <= 1'b0;
      smp_prev <= 1'b0;
    end else begin
      smp_now  <= lvl_in;
      smp_prev <= smp_now;
    end
  end

  assign restart = smp_now ^ smp_prev;

  AST_HISTORY_CLEARED: assert property (@(posedge clk) rst |=> !restart); // R1
endmodule

// File: rtl/itimer_slot.sv
module itimer_slot #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic done
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TERM = CW'(LIMIT);

  logic [CW-1:0] count;
  logic [CW-1:0] nxt;

  assign nxt = count + CW'(1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count <= '0;
      done  <= 1'b0;
    end else if (tick && !done) begin
      count <= nxt;
      if (nxt == TERM) done <= 1'b1;
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!done && count == '0)); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> ($stable(count) && $stable(done))); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !restart) |=> done); // R6
  AST_RISE_AT_TERM: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (count == TERM)); // R3 R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= TERM); // R3
endmodule

// File: rtl/toggle_interval_timer.sv
module toggle_interval_timer
  import itimer_pkg::*;
#(
  parameter int LONG_TICKS  = DEF_LONG_TICKS,
  parameter int SHORT_TICKS = DEF_SHORT_TICKS
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start_lvl,
  output logic long_done,
  output logic short_done
);
  logic                 restart;
  logic [NUM_SLOTS-1:0] done_vec;

  itimer_toggle_det u_det (
    .clk     (clk),
    .rst     (rst),
    .lvl_in  (start_lvl),
    .restart (restart)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int LIM = (g == SLOT_LONG) ? LONG_TICKS : SHORT_TICKS;
    itimer_slot #(.LIMIT(LIM)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .tick    (tick),
      .done    (done_vec[g])
    );
  end

  assign long_done  = done_vec[SLOT_LONG];
  assign short_done = done_vec[SLOT_SHORT];

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (!long_done && !short_done)); // R1
endmodule

// File: tb/toggle_interval_timer_test.sv
module toggle_interval_timer_test;
  localparam int LT = 12;
  localparam int ST = 3;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic start_lvl = 1'b0;
  logic long_done, short_done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  toggle_interval_timer #(.LONG_TICKS(LT), .SHORT_TICKS(ST)) uut (
    .clk(clk), .rst(rst), .tick(tick), .start_lvl(start_lvl),
    .long_done(long_done), .short_done(short_done)
  );

  // behavioural reference
  int m_now = 0, m_prev = 0, m_lc = 0, m_sc = 0, m_lf = 0, m_sf = 0;
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_now = 0; m_prev = 0; m_lc = 0; m_sc = 0; m_lf = 0; m_sf = 0;
    end else begin
      if (m_now != m_prev) begin
        m_lc = 0; m_sc = 0; m_lf = 0; m_sf = 0;
      end else if (tick) begin
        if (m_lf == 0) begin m_lc++; if (m_lc == LT) m_lf = 1; end
        if (m_sf == 0) begin m_sc++; if (m_sc == ST) m_sf = 1; end
      end
      m_prev = m_now;
      m_now = int'(start_lvl);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks += 2;
      if (int'(long_done) != m_lf) begin
        fails++;
        $display("FAIL R3 model long_done act=%0d exp=%0d cyc=%0d", long_done, m_lf, cycles);
      end
      if (int'(short_done) != m_sf) begin
        fails++;
        $display("FAIL R4 model short_done act=%0d exp=%0d cyc=%0d", short_done, m_sf, cycles);
      end
    end
  end

  task automatic cyc(input logic s, input logic t);
    start_lvl = s; tick = t;
    @(negedge clk);
  endtask

  task automatic expect2(input logic el, input logic es, input string req);
    checks++;
    if (long_done !== el || short_done !== es) begin
      fails++;
      $display("FAIL %s act long=%b short=%b exp long=%b short=%b", req, long_done, short_done, el, es);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * MAX_CYC);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    logic lvl;
    lfsr = 16'hACE1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1);
    expect2(1'b0, 1'b0, "R1 reset");
    rst = 1'b0;
    cmp_on = 1'b1;
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0);
    expect2(1'b0, 1'b0, "R5 no ticks");
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
    expect2(1'b0, 1'b0, "R4 before short limit");
    cyc(1'b0, 1'b1);
    expect2(1'b0, 1'b1, "R4 short at limit");
    for (int i = 0; i < LT - ST - 1; i++) cyc(1'b0, 1'b1);
    expect2(1'b0, 1'b1, "R3 before long limit");
    cyc(1'b0, 1'b1);
    expect2(1'b1, 1'b1, "R3 long at limit");
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0);
    expect2(1'b1, 1'b1, "R6 sticky");
    cyc(1'b1, 1'b0);
    expect2(1'b1, 1'b1, "R2 rising sampled");
    cyc(1'b1, 1'b0);
    expect2(1'b0, 1'b0, "R2 rising restart");
    cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
    expect2(1'b0, 1'b0, "R2 count from zero");
    cyc(1'b1, 1'b1);
    expect2(1'b0, 1'b1, "R2 short after restart");
    cyc(1'b0, 1'b1);
    expect2(1'b0, 1'b1, "R7 falling sampled");
    cyc(1'b0, 1'b1);
    expect2(1'b0, 1'b0, "R2 falling restart");
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
    expect2(1'b0, 1'b0, "R7 coincident tick not counted");
    cyc(1'b0, 1'b1);
    expect2(1'b0, 1'b1, "R7 short after third tick");
    lvl = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[9:5] == 5'd0) lvl = ~lvl;
      cyc(lvl, lfsr[0] | lfsr[1]);
    end
    rst = 1'b1;
    cyc(lvl, 1'b1);
    cyc(lvl, 1'b1);
    expect2(1'b0, 1'b0, "R1 reset mid-run");
    finish_run();
  end
endmodule